// File: doc/BRIEF.md
# Latched Channel-Select Decoder with Break-Before-Make

This block drives the switch enables of an eight-input analog multiplexer from a processor write cycle. Software presents a channel address and an enable bit together with an active-low write strobe. While the strobe is low, the stored selection follows the inputs. When the strobe returns high, the values that were present at that moment are kept until the next write. Because the enable bit is stored with the address, one write can also turn every switch off.

The stored selection is decoded to a vector of switch enables. In single-ended mode one of eight bits is set. In differential mode (parameter `DIFF`) a 2-bit address picks one of four pairs, and both halves of that pair are driven together. Whenever the selection moves from one closed switch to a different one, the block drives every enable low for `GAP_CYCLES` clock cycles before it closes the new switch, so two channels are never connected at once.

An active-low master reset clears the stored state and opens every switch at once. It overrides a write that is in progress. All inputs are asynchronous to the clock and pass through two-stage synchronizers. The reset asserts asynchronously and is released synchronously. No data stream passes through the block, so every pin is plain control and there is no valid/ready handshake.

Top module: `chsel_top`

## Requirements
- R1: In single-ended mode (`DIFF`=0), a stored enable of 1 with stored address n (0 to 7) drives `sw_en` to exactly bit n set. Address 0 is switch 1 and address 7 is switch 8.
- R2: In differential mode (`DIFF`=1), a stored enable of 1 with stored address k (0 to 3) sets exactly bits k and k+4 of `sw_en`. Bits 3:0 are the a-side enables and bits 7:4 are the b-side enables.
- R3: While `wr_n` is low the stored selection is transparent. A change of `addr` or `en` made during a long low strobe reaches `sw_en`.
- R4: While `wr_n` is high the stored selection holds the values present when the strobe rose. Later changes on `addr` and `en` do not change `sw_en`.
- R5: While `rst_n` is low, `sw_en` is all zero at every clock edge, even when `wr_n` is low with the enable set. The stored state is cleared.
- R6: After `rst_n` is released, `sw_en` stays zero until a write with the enable bit set completes.
- R7: When the stored enable bit is 0, `sw_en` is zero for every address.
- R8: When the selection changes from one nonzero enable pattern to a different nonzero one, `sw_en` is all zero for exactly `GAP_CYCLES` cycles in between. The pattern never changes directly from one closed switch to another.
- R9: Writing the currently active address and enable again leaves `sw_en` unchanged, with no all-zero cycle.
- R10: With no gap pending, a change applied on the inputs with the strobe low appears on `sw_en` after four rising clock edges. This covers turning on from all-off and turning off from one switch, and neither inserts a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assert, synchronized release |
| wr_n | input | 1 | Active-low write strobe; the storage is transparent while it is low |
| en | input | 1 | Enable bit stored with the address |
| addr | input | ADDR_W | Channel address: 3 bits single-ended, 2 bits differential |
| sw_en | output | 8 | Switch enables: one-hot, or a paired a/b pattern in differential mode |

## Verification
The bench walks every pair of {enable, address} states through both a single-ended and a differential instance, which share their inputs. It measures the all-off run on each switch-to-switch move. A design that skipped or shortened the gap would show a direct jump between two closed switches, or a zero run that is too short. A design that applied the gap too widely would blank the output on a repeated write, or delay turn-on from all-off. Separate sequences change the address during a long low strobe and again after the strobe has risen. They also assert reset in the middle of an enabled write. These sequences expose a design that captures on the wrong strobe level, or that lets the write win over reset or re-arm after reset is released.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int SW_W = 8;
  typedef logic [SW_W-1:0] sw_vec_t;

  // one-hot select of a single switch
  function automatic sw_vec_t single_sel(input logic [2:0] a);
    sw_vec_t v;
    v = '0;
    v[a] = 1'b1;
    return v;
  endfunction

  // paired select: a-side at k, b-side at k+4
  function automatic sw_vec_t pair_sel(input logic [1:0] k);
    sw_vec_t v;
    v = '0;
    v[k] = 1'b1;
    v[{1'b1, k}] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int          W       = 5,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chsel_store.sv
module chsel_store #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              en_q,
  output logic [ADDR_W-1:0] addr_q
);
  // transparent while the strobe is low, holding while it is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else if (!wr_n) begin
      en_q   <= en;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm #(
  parameter int SW_W       = 8,
  parameter int GAP_CYCLES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] target,
  output logic [SW_W-1:0] sw_en
);
  localparam int CNT_W = $clog2(GAP_CYCLES) + 1;
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] gap_cnt;
  logic             swap;

  // a move between two closed switches must pass through all-off
  assign swap = (sw_en != '0) && (target != '0) && (target != sw_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en   <= '0;
      gap_cnt <= '0;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end else if (swap) begin
      sw_en   <= '0;
      gap_cnt <= GAP_LOAD;
    end else begin
      sw_en   <= target;
    end
  end
endmodule

// File: rtl/chsel_top.sv
module chsel_top #(
  parameter int DIFF        = 0,
  parameter int GAP_CYCLES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = (DIFF != 0) ? 2 : 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        sw_en
);
  import chsel_pkg::*;

  localparam int IN_W = ADDR_W + 2;
  localparam logic [IN_W-1:0] IN_IDLE = {1'b1, {(IN_W-1){1'b0}}};

  logic              rst_i;
  logic [IN_W-1:0]   in_s;
  logic              wr_s;
  logic              en_s;
  logic [ADDR_W-1:0] addr_s;
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  sw_vec_t           target;

  chsel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_o(rst_i)
  );

  chsel_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_in_sync (
    .clk(clk), .rst_n(rst_i), .d({wr_n, en, addr}), .q(in_s)
  );

  assign {wr_s, en_s, addr_s} = in_s;

  chsel_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_i), .wr_n(wr_s), .en(en_s), .addr(addr_s),
    .en_q(en_q), .addr_q(addr_q)
  );

  generate
    if (DIFF != 0) begin : g_pair
      always_comb target = en_q ? pair_sel(addr_q[1:0]) : '0;
    end else begin : g_single
      always_comb target = en_q ? single_sel(addr_q[2:0]) : '0;
    end
  endgenerate

  chsel_bbm #(.SW_W(SW_W), .GAP_CYCLES(GAP_CYCLES)) u_bbm (
    .clk(clk), .rst_n(rst_i), .target(target), .sw_en(sw_en)
  );
endmodule

// File: rtl/chsel_chk.sv
module chsel_chk #(
  parameter int DIFF   = 0,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_i,
  input logic              wr_s,
  input logic              en_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [7:0]        sw_en
);
  // R1 R2
  shape_ok_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (DIFF != 0) ? (sw_en[3:0] == sw_en[7:4] && $onehot0(sw_en[3:0])) : $onehot0(sw_en));

  // R4
  hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wr_s |=> $stable({en_q, addr_q}));

  // R5
  reset_off_chk: assert property (@(posedge clk)
    !rst_n |-> (sw_en == 8'h00));

  // R7
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |=> (sw_en == 8'h00));

  // R8
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (sw_en != 8'h00) |=> (sw_en == 8'h00 || sw_en == $past(sw_en)));
endmodule

bind chsel_top chsel_chk #(.DIFF(DIFF), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_i(rst_i), .wr_s(wr_s),
  .en_q(en_q), .addr_q(addr_q), .sw_en(sw_en)
);

// File: tb/tb_chsel_top.sv
module tb_chsel_top;
  localparam int GS  = 2;   // gap of the single-ended instance
  localparam int GD  = 3;   // gap of the differential instance
  localparam int WIN = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic       en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] sw_s, sw_d;
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  chsel_top #(.DIFF(0), .GAP_CYCLES(GS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en_i), .addr(addr_i), .sw_en(sw_s)
  );
  chsel_top #(.DIFF(1), .GAP_CYCLES(GD)) dut_d (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en_i), .addr(addr_i[1:0]), .sw_en(sw_d)
  );

  function automatic logic [7:0] exp_s(input logic e, input logic [2:0] a);
    return e ? (8'd1 << a) : 8'd0;
  endfunction
  function automatic logic [7:0] exp_d(input logic e, input logic [1:0] a);
    return e ? (8'h11 << a) : 8'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous monitor: pattern shape and no direct switch-to-switch move (R1 R2 R8)
  logic [7:0] last_s = 8'd0, last_d = 8'd0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 single one-hot", ($countones(sw_s) <= 1), 1);
      check("R2 paired halves", (sw_d[3:0] == sw_d[7:4] && $countones(sw_d) <= 2), 1);
      check("R8 single no direct swap",
            !(last_s != 0 && sw_s != 0 && sw_s != last_s), 1);
      check("R8 diff no direct swap",
            !(last_d != 0 && sw_d != 0 && sw_d != last_d), 1);
    end
    last_s = sw_s;
    last_d = sw_d;
  end

  task automatic step(input logic e, input logic [2:0] a);
    logic [7:0] ps, pd, ns, nd;
    int zs, zd, fs, fd;
    ps = sw_s; pd = sw_d;
    ns = exp_s(e, a); nd = exp_d(e, a[1:0]);
    zs = 0; zd = 0; fs = 0; fd = 0;
    @(negedge clk);
    en_i = e; addr_i = a; wr_n = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (sw_s == 8'd0) zs++;
      if (sw_d == 8'd0) zd++;
      if (fs == 0 && sw_s == ns) fs = k;
      if (fd == 0 && sw_d == nd) fd = k;
    end
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    check(e ? "R1 single final" : "R7 single disabled", sw_s, ns);
    check(e ? "R2 diff final" : "R7 diff disabled", sw_d, nd);
    if (ps != 0 && ns != 0 && ps != ns) begin
      check("R8 single gap length", zs, GS);
      check("R8 single arrival", fs, 4 + GS);
    end else if (ps == ns && ns != 0) begin
      check("R9 single rewrite no gap", zs, 0);
    end else if (ps != ns) begin
      check("R10 single latency", fs, 4);
    end
    if (pd != 0 && nd != 0 && pd != nd) begin
      check("R8 diff gap length", zd, GD);
      check("R8 diff arrival", fd, 4 + GD);
    end else if (pd == nd && nd != 0) begin
      check("R9 diff rewrite no gap", zd, 0);
    end else if (pd != nd) begin
      check("R10 diff latency", fd, 4);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R5 reset state single", sw_s, 0);
    check("R5 reset state diff", sw_d, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R6 off after release single", sw_s, 0);
    check("R6 off after release diff", sw_d, 0);

    // exhaustive pairs of {en, addr}
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 16; t++) begin
        step(f[3], f[2:0]);
        step(t[3], t[2:0]);
      end
    end

    // R3: transparency during a long low strobe
    @(negedge clk);
    en_i = 1'b1; addr_i = 3'd1; wr_n = 1'b0;
    repeat (14) @(negedge clk);
    addr_i = 3'd6;
    repeat (14) @(negedge clk);
    check("R3 single follows while low", sw_s, 8'h40);
    check("R3 diff follows while low", sw_d, 8'h44);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    // R4: changes after the rising strobe are ignored
    addr_i = 3'd3; en_i = 1'b0;
    repeat (14) @(negedge clk);
    check("R4 single holds", sw_s, 8'h40);
    check("R4 diff holds", sw_d, 8'h44);

    // R5: reset in the middle of an enabled write
    en_i = 1'b1; addr_i = 3'd5; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R5 reset clears single", sw_s, 0);
    check("R5 reset clears diff", sw_d, 0);
    repeat (6) @(negedge clk);
    check("R5 reset beats write single", sw_s, 0);
    check("R5 reset beats write diff", sw_d, 0);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (14) @(negedge clk);
    check("R6 stays off single", sw_s, 0);
    check("R6 stays off diff", sw_d, 0);
    step(1'b0, 3'd2);
    check("R6 disabled write keeps off", sw_s, 0);
    step(1'b1, 3'd2);
    check("R6 enabled write turns on", sw_s, 8'h04);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule